// File: doc/BRIEF.md
# Timer Register File with Halfword Access

This block is the software-facing register set of a general purpose timer. It sits on a simple synchronous bus that carries an address, read and write enables, an access size, write data and read data. Reads return data in the same cycle as the request. Writes take effect at the clock edge that ends the write cycle. The counting and capture datapaths live elsewhere. This block hands them decoded control fields, the load and match values, and single-cycle strobes for reload, counter write, capture re-arm and soft reset. It reads back their counter and capture values.

Three event strobes come in from the datapaths: match, overflow and capture. Each strobe sets its interrupt status bit when that event's interrupt enable is set. The interrupt line is a level that stays high while any status bit is set. A separate wakeup output pulses for one cycle after any event whose wakeup enable is set. Sixteen-bit accesses are supported as pairs. A lower-half write is held until the upper-half write commits both halves together. A lower-half read captures the upper half so that the next upper-half read returns it.

Top module: `tmr_regfile`

## Requirements
- R1: After reset, the interrupt and wakeup outputs are low. The control fields, load value and match value are zero. The config register reads 0. The interface-control register reads 0x4.
- R2: Some offsets return fixed values: 0x00 reads 0x21, 0x14 reads 1, 0x34 reads 0 and 0x30 reads 0xFFFFFFFF. Writes to these offsets, and to the capture offsets 0x3C and 0x44, change nothing.
- R3: Status (offset 0x18) uses bit 0 for match, bit 1 for overflow and bit 2 for capture. An event sets its status bit one cycle later only if the matching bit of the interrupt-enable register (offset 0x1C) is set. The enable register and the wakeup-enable register (offset 0x20) keep only bits 2:0.
- R4: The interrupt output is high exactly while some status bit is set. Writing ones to offset 0x18 clears those bits. When an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: The wakeup output is high for the one cycle after an event whose wakeup-enable bit is set. This holds whatever the interrupt enable and status bits are.
- R6: The control register (offset 0x24) drives its fields as follows:
  - start: bit 0
  - auto-reload: bit 1
  - prescale value: bits 4:2
  - prescale enable: bit 5
  - compare enable: bit 6
  - default level: bit 7
  - capture mode: bits 9:8
  - trigger mode: bits 11:10
  - toggle: bit 12
  - second-capture select: bit 13
  - pin direction: bit 14

  The register reads back bits 14:0.
- R7: A 16-bit write to a lower half (address bit 1 clear) changes no register. A 16-bit write to an upper half commits a 32-bit write to that word. The upper 16 bits come from the upper-half write and the lower 16 bits from the buffered lower-half data.
- R8: A 16-bit read of a lower half returns the low 16 bits of the word and latches its high 16 bits. A following 16-bit read of an upper half returns the latched bits, even if the word has changed since.
- R9: A write to the config register (offset 0x10) stores the written value ANDed with 0x33D.
- R10: A write with bit 1 set to either offset 0x10 or offset 0x40 pulses the soft-reset strobe in that cycle. It also returns every register to its reset value.
- R11: Writing offset 0x30 pulses the reload strobe. Writing offset 0x28 pulses the counter-write strobe and presents the written data. Reading offset 0x28 returns the counter input.
- R12: Bit 2 of offset 0x40 holds the posted flag. Its reset value is 1.
- R13: 8-bit accesses are rejected. Their writes change nothing and their reads return 0.
- R14: The capture re-arm strobe pulses in two cases: a status write with bit 2 set, or a control write that moves the capture mode from 0 to a nonzero value. A control write that changes the capture mode between two nonzero values does not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| evt_match | input | 1 | Match event strobe |
| evt_ovf | input | 1 | Overflow event strobe |
| evt_capt | input | 1 | Capture event strobe |
| cnt_val | input | 32 | Current counter value for readback |
| capt1_val | input | 32 | First capture value for readback |
| capt2_val | input | 32 | Second capture value for readback |
| irq | output | 1 | Level interrupt |
| wake | output | 1 | One-cycle wakeup pulse |
| ctl_start | output | 1 | Counter run |
| ctl_autoreload | output | 1 | Reload on overflow |
| ctl_prescale | output | 3 | Prescale value |
| ctl_pre_en | output | 1 | Prescale enable |
| ctl_cmp_en | output | 1 | Compare enable |
| ctl_def_level | output | 1 | Idle output level |
| ctl_capt_mode | output | 2 | Capture edge mode |
| ctl_trig_mode | output | 2 | Output trigger mode |
| ctl_toggle | output | 1 | Toggle versus pulse output |
| ctl_capt2 | output | 1 | Interrupt on second capture |
| ctl_pin_in | output | 1 | Pin is an input |
| load_value | output | 32 | Reload value |
| match_value | output | 32 | Compare value |
| reload_req | output | 1 | Reload strobe |
| cnt_wr | output | 1 | Counter write strobe |
| cnt_wdata | output | 32 | Counter write data |
| capt_rearm | output | 1 | Capture count reset strobe |
| srst_pulse | output | 1 | Soft reset strobe |

## Verification
The status register can be hit in one cycle by an event strobe that sets a bit and by a software write of ones that clears it. The design must let the set win.

The bench provokes this overlap in two ways. A directed case raises the match event in the same cycle as a clear of bit 0. A random loop then mixes event strobes, clear masks and enable values. After each step the interrupt level, the wakeup pulse and the read-back status are compared against a bench model that applies the clear before the set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [7:0] OFF_ID    = 8'h00;
  localparam logic [7:0] OFF_CFG   = 8'h10;
  localparam logic [7:0] OFF_SYS   = 8'h14;
  localparam logic [7:0] OFF_ISR   = 8'h18;
  localparam logic [7:0] OFF_IER   = 8'h1C;
  localparam logic [7:0] OFF_IWER  = 8'h20;
  localparam logic [7:0] OFF_CTL   = 8'h24;
  localparam logic [7:0] OFF_CNT   = 8'h28;
  localparam logic [7:0] OFF_LOAD  = 8'h2C;
  localparam logic [7:0] OFF_TRIG  = 8'h30;
  localparam logic [7:0] OFF_WPEND = 8'h34;
  localparam logic [7:0] OFF_MATCH = 8'h38;
  localparam logic [7:0] OFF_CAP1  = 8'h3C;
  localparam logic [7:0] OFF_IFC   = 8'h40;
  localparam logic [7:0] OFF_CAP2  = 8'h44;

  localparam logic [31:0] ID_VALUE = 32'h21;
  localparam logic [9:0]  CFG_MASK = 10'h33D;

  typedef struct packed {
    logic       pin_in;
    logic       capt2;
    logic       toggle;
    logic [1:0] trig;
    logic [1:0] capt;
    logic       def_lvl;
    logic       cmp_en;
    logic       pre_en;
    logic [2:0] ptv;
    logic       autoreload;
    logic       start;
  } ctl_t;

  function automatic logic [31:0] merge_half(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [2:0] w1c_next(input logic [2:0] cur, input logic [2:0] clr,
                                          input logic [2:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/tmr_bus_adapt.sv
module tmr_bus_adapt
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic [31:0]       word_rdata,
  output logic [31:0]       bus_rdata,
  output logic              cmt_we,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [31:0]       cmt_wdata
);
  logic [15:0] lo_buf_q;
  logic [15:0] hi_lat_q;
  logic        is_word, is_half, upper;

  assign is_word = (bus_size == SZ_WORD);
  assign is_half = (bus_size == SZ_HALF);
  assign upper   = bus_addr[1];

  always_comb begin
    cmt_we    = bus_wr && (is_word || (is_half && upper));
    cmt_addr  = {bus_addr[ADDR_W-1:2], 2'b00};
    cmt_wdata = is_word ? bus_wdata : merge_half(bus_wdata[15:0], lo_buf_q);
    if (is_word)             bus_rdata = word_rdata;
    else if (is_half && !upper) bus_rdata = {16'h0, word_rdata[15:0]};
    else if (is_half)        bus_rdata = {16'h0, hi_lat_q};
    else                     bus_rdata = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_buf_q <= '0;
      hi_lat_q <= '0;
    end else begin
      if (bus_wr && is_half && !upper) lo_buf_q <= bus_wdata[15:0];
      if (bus_rd && is_half && !upper) hi_lat_q <= word_rdata[31:16];
    end
  end

  assert_lower_half_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_half && !upper) |-> !cmt_we);
  assert_byte_rejected_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_size == SZ_BYTE) |-> (!cmt_we && bus_rdata == 32'h0));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_pkg::*;
#(
  parameter int N_EVT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] int_en,
  input  logic [N_EVT-1:0] wake_en,
  input  logic             clr_we,
  input  logic [N_EVT-1:0] clr_mask,
  output logic [N_EVT-1:0] status,
  output logic             irq,
  output logic             wake
);
  logic [N_EVT-1:0] st_q;
  logic [N_EVT-1:0] set_vec, clr_vec;
  logic             wake_q;

  assign set_vec = evt & int_en;
  assign clr_vec = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st_q   <= '0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= w1c_next(st_q, clr_vec, set_vec);
      wake_q <= |(evt & wake_en);
    end
  end

  assign status = st_q;
  assign irq    = |st_q;
  assign wake   = wake_q;

  assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_q & ~$past(st_q))) |-> (|$past(evt & int_en)));
  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_we) && $past(evt) == '0) |-> ((st_q & $past(clr_mask)) == '0));
  assert_wake_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|$past(evt & wake_en)));
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_EVT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_match,
  input  logic              evt_ovf,
  input  logic              evt_capt,
  input  logic [31:0]       cnt_val,
  input  logic [31:0]       capt1_val,
  input  logic [31:0]       capt2_val,
  output logic              irq,
  output logic              wake,
  output logic              ctl_start,
  output logic              ctl_autoreload,
  output logic [2:0]        ctl_prescale,
  output logic              ctl_pre_en,
  output logic              ctl_cmp_en,
  output logic              ctl_def_level,
  output logic [1:0]        ctl_capt_mode,
  output logic [1:0]        ctl_trig_mode,
  output logic              ctl_toggle,
  output logic              ctl_capt2,
  output logic              ctl_pin_in,
  output logic [31:0]       load_value,
  output logic [31:0]       match_value,
  output logic              reload_req,
  output logic              cnt_wr,
  output logic [31:0]       cnt_wdata,
  output logic              capt_rearm,
  output logic              srst_pulse
);
  localparam int CTL_W = $bits(ctl_t);
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_SYS   = ADDR_W'(OFF_SYS);
  localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(OFF_ISR);
  localparam logic [ADDR_W-1:0] A_IER   = ADDR_W'(OFF_IER);
  localparam logic [ADDR_W-1:0] A_IWER  = ADDR_W'(OFF_IWER);
  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFF_TRIG);
  localparam logic [ADDR_W-1:0] A_WPEND = ADDR_W'(OFF_WPEND);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFF_MATCH);
  localparam logic [ADDR_W-1:0] A_CAP1  = ADDR_W'(OFF_CAP1);
  localparam logic [ADDR_W-1:0] A_IFC   = ADDR_W'(OFF_IFC);
  localparam logic [ADDR_W-1:0] A_CAP2  = ADDR_W'(OFF_CAP2);

  logic              cmt_we;
  logic [ADDR_W-1:0] cmt_addr;
  logic [31:0]       cmt_wdata;
  logic [31:0]       word_rdata;
  logic [ADDR_W-1:0] rd_addr;

  logic [9:0]        cfg_q;
  logic [N_EVT-1:0]  ie_q, we_q, status;
  ctl_t              ctl_q;
  logic [31:0]       load_q, match_q;
  logic              posted_q;
  logic              srst, isr_we;

  tmr_bus_adapt #(.ADDR_W(ADDR_W)) u_adapt (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .word_rdata(word_rdata),
    .bus_rdata(bus_rdata), .cmt_we(cmt_we), .cmt_addr(cmt_addr), .cmt_wdata(cmt_wdata)
  );

  assign isr_we = cmt_we && (cmt_addr == A_ISR);
  assign srst   = cmt_we && cmt_wdata[1] && (cmt_addr == A_CFG || cmt_addr == A_IFC);

  tmr_irq_ctrl #(.N_EVT(N_EVT)) u_irq (
    .clk(clk), .rst_n(rst_n), .srst(srst), .evt({evt_capt, evt_ovf, evt_match}),
    .int_en(ie_q), .wake_en(we_q), .clr_we(isr_we), .clr_mask(cmt_wdata[N_EVT-1:0]),
    .status(status), .irq(irq), .wake(wake)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      cfg_q    <= '0;
      ie_q     <= '0;
      we_q     <= '0;
      ctl_q    <= '0;
      load_q   <= '0;
      match_q  <= '0;
      posted_q <= 1'b1;
    end else if (cmt_we) begin
      case (cmt_addr)
        A_CFG:   cfg_q    <= cmt_wdata[9:0] & CFG_MASK;
        A_IER:   ie_q     <= cmt_wdata[N_EVT-1:0];
        A_IWER:  we_q     <= cmt_wdata[N_EVT-1:0];
        A_CTL:   ctl_q    <= ctl_t'(cmt_wdata[CTL_W-1:0]);
        A_LOAD:  load_q   <= cmt_wdata;
        A_MATCH: match_q  <= cmt_wdata;
        A_IFC:   posted_q <= cmt_wdata[2];
        default: ;
      endcase
    end
  end

  assign rd_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  always_comb begin
    case (rd_addr)
      A_ID:    word_rdata = ID_VALUE;
      A_CFG:   word_rdata = {22'h0, cfg_q};
      A_SYS:   word_rdata = 32'h1;
      A_ISR:   word_rdata = {{(32-N_EVT){1'b0}}, status};
      A_IER:   word_rdata = {{(32-N_EVT){1'b0}}, ie_q};
      A_IWER:  word_rdata = {{(32-N_EVT){1'b0}}, we_q};
      A_CTL:   word_rdata = {{(32-CTL_W){1'b0}}, ctl_q};
      A_CNT:   word_rdata = cnt_val;
      A_LOAD:  word_rdata = load_q;
      A_TRIG:  word_rdata = 32'hFFFF_FFFF;
      A_WPEND: word_rdata = 32'h0;
      A_MATCH: word_rdata = match_q;
      A_CAP1:  word_rdata = capt1_val;
      A_IFC:   word_rdata = {29'h0, posted_q, 2'b00};
      A_CAP2:  word_rdata = capt2_val;
      default: word_rdata = 32'h0;
    endcase
  end

  assign ctl_start      = ctl_q.start;
  assign ctl_autoreload = ctl_q.autoreload;
  assign ctl_prescale   = ctl_q.ptv;
  assign ctl_pre_en     = ctl_q.pre_en;
  assign ctl_cmp_en     = ctl_q.cmp_en;
  assign ctl_def_level  = ctl_q.def_lvl;
  assign ctl_capt_mode  = ctl_q.capt;
  assign ctl_trig_mode  = ctl_q.trig;
  assign ctl_toggle     = ctl_q.toggle;
  assign ctl_capt2      = ctl_q.capt2;
  assign ctl_pin_in     = ctl_q.pin_in;
  assign load_value     = load_q;
  assign match_value    = match_q;

  assign reload_req = cmt_we && (cmt_addr == A_TRIG);
  assign cnt_wr     = cmt_we && (cmt_addr == A_CNT);
  assign cnt_wdata  = cmt_wdata;
  assign capt_rearm = (isr_we && cmt_wdata[2]) ||
                      (cmt_we && cmt_addr == A_CTL && ctl_q.capt == 2'b00 && cmt_wdata[9:8] != 2'b00);
  assign srst_pulse = srst;

  assert_srst_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> (load_value == 32'h0 && ctl_q == '0 && posted_q && !irq));
  assert_posted_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_we && cmt_addr == A_IFC && !cmt_wdata[1]) |=> (posted_q == $past(cmt_wdata[2])));
  assert_cfg_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~CFG_MASK) == 10'h0);
endmodule

// File: tb/tmr_regfile_tb.sv
module tmr_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_match = 0, evt_ovf = 0, evt_capt = 0;
  logic [31:0] cnt_val = 32'h0BAD_0C0D, capt1_val = 32'hCAFE_0001, capt2_val = 32'hCAFE_0002;
  logic        irq, wake;
  logic        ctl_start, ctl_autoreload, ctl_pre_en, ctl_cmp_en, ctl_def_level;
  logic [2:0]  ctl_prescale;
  logic [1:0]  ctl_capt_mode, ctl_trig_mode;
  logic        ctl_toggle, ctl_capt2, ctl_pin_in;
  logic [31:0] load_value, match_value, cnt_wdata;
  logic        reload_req, cnt_wr, capt_rearm, srst_pulse;

  int checks = 0;
  int errors = 0;
  logic        s_reload, s_cntwr, s_rearm, s_srst;
  logic [31:0] s_cntdata;

  always #4 clk = ~clk;

  tmr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_match(evt_match), .evt_ovf(evt_ovf), .evt_capt(evt_capt),
    .cnt_val(cnt_val), .capt1_val(capt1_val), .capt2_val(capt2_val),
    .irq(irq), .wake(wake), .ctl_start(ctl_start), .ctl_autoreload(ctl_autoreload),
    .ctl_prescale(ctl_prescale), .ctl_pre_en(ctl_pre_en), .ctl_cmp_en(ctl_cmp_en),
    .ctl_def_level(ctl_def_level), .ctl_capt_mode(ctl_capt_mode), .ctl_trig_mode(ctl_trig_mode),
    .ctl_toggle(ctl_toggle), .ctl_capt2(ctl_capt2), .ctl_pin_in(ctl_pin_in),
    .load_value(load_value), .match_value(match_value), .reload_req(reload_req),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .capt_rearm(capt_rearm), .srst_pulse(srst_pulse)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_w(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    #1;
    s_reload = reload_req; s_cntwr = cnt_wr; s_rearm = capt_rearm;
    s_srst = srst_pulse; s_cntdata = cnt_wdata;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 2'd2;
  endtask

  task automatic bus_r(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_size = 2'd2;
  endtask

  function automatic logic [31:0] ctl_out_word();
    return {17'h0, ctl_pin_in, ctl_capt2, ctl_toggle, ctl_trig_mode, ctl_capt_mode,
            ctl_def_level, ctl_cmp_en, ctl_pre_en, ctl_prescale, ctl_autoreload, ctl_start};
  endfunction

  function automatic logic [2:0] model_status(input logic [2:0] cur, input logic [2:0] clr,
                                              input logic [2:0] ev, input logic [2:0] en);
    logic [2:0] r;
    r = cur;
    for (int b = 0; b < 3; b++) begin
      if (clr[b]) r[b] = 1'b0;
      if (ev[b] && en[b]) r[b] = 1'b1;
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    logic [2:0]  ie_m, we_m, st_m, ev, clr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 wake", {31'h0, wake}, 32'h0);
    chk("R1 ctl", ctl_out_word(), 32'h0);
    chk("R1 load", load_value, 32'h0);
    chk("R1 match", match_value, 32'h0);
    bus_r(8'h10, 2'd2, v); chk("R1 cfg", v, 32'h0);
    bus_r(8'h40, 2'd2, v); chk("R1 R12 ifc posted", v, 32'h4);

    // R2 fixed and read-only offsets
    bus_r(8'h00, 2'd2, v); chk("R2 id", v, 32'h21);
    bus_r(8'h14, 2'd2, v); chk("R2 sys", v, 32'h1);
    bus_r(8'h34, 2'd2, v); chk("R2 wpend", v, 32'h0);
    bus_r(8'h30, 2'd2, v); chk("R2 trig", v, 32'hFFFF_FFFF);
    bus_w(8'h00, 2'd2, 32'h1234_5678); bus_r(8'h00, 2'd2, v); chk("R2 id write", v, 32'h21);
    bus_w(8'h14, 2'd2, 32'h0); bus_r(8'h14, 2'd2, v); chk("R2 sys write", v, 32'h1);
    bus_w(8'h3C, 2'd2, 32'h0); bus_r(8'h3C, 2'd2, v); chk("R2 cap1", v, capt1_val);
    bus_w(8'h44, 2'd2, 32'h0); bus_r(8'h44, 2'd2, v); chk("R2 cap2", v, capt2_val);
    chk("R2 no side effect", {28'h0, s_srst, s_reload, s_cntwr, s_rearm}, 32'h0);

    // R6 control fields, random
    for (int i = 0; i < 20; i++) begin
      w = $urandom;
      bus_w(8'h24, 2'd2, w);
      chk("R6 ctl outputs", ctl_out_word(), w & 32'h7FFF);
      bus_r(8'h24, 2'd2, v); chk("R6 ctl readback", v, w & 32'h7FFF);
    end
    bus_w(8'h24, 2'd2, 32'h0);

    // R9 config mask
    for (int i = 0; i < 6; i++) begin
      w = $urandom & ~32'h2;
      bus_w(8'h10, 2'd2, w);
      bus_r(8'h10, 2'd2, v); chk("R9 cfg mask", v, w & 32'h33D);
    end

    // R10 soft reset via config and via interface control
    bus_w(8'h2C, 2'd2, 32'hA5A5_0001);
    bus_w(8'h24, 2'd2, 32'h0000_4003);
    bus_w(8'h10, 2'd2, 32'h0000_0002);
    chk("R10 srst strobe cfg", {31'h0, s_srst}, 32'h1);
    chk("R10 load cleared", load_value, 32'h0);
    chk("R10 ctl cleared", ctl_out_word(), 32'h0);
    bus_r(8'h10, 2'd2, v); chk("R10 cfg cleared", v, 32'h0);
    bus_w(8'h40, 2'd2, 32'h0); bus_r(8'h40, 2'd2, v); chk("R12 posted cleared", v, 32'h0);
    bus_w(8'h38, 2'd2, 32'h0000_0777);
    bus_w(8'h40, 2'd2, 32'h0000_0002);
    chk("R10 srst strobe ifc", {31'h0, s_srst}, 32'h1);
    chk("R10 match cleared", match_value, 32'h0);
    bus_r(8'h40, 2'd2, v); chk("R10 R12 posted restored", v, 32'h4);
    bus_w(8'h40, 2'd2, 32'h0000_0004); bus_r(8'h40, 2'd2, v); chk("R12 posted set", v, 32'h4);

    // R7 halfword writes
    bus_w(8'h2C, 2'd1, 32'h0000_BEEF);
    chk("R7 lower half held", load_value, 32'h0);
    bus_w(8'h2E, 2'd1, 32'h0000_DEAD);
    chk("R7 upper commits", load_value, 32'hDEAD_BEEF);
    bus_w(8'h38, 2'd1, 32'h0000_1234);
    bus_w(8'h3A, 2'd1, 32'hFFFF_5678);
    chk("R7 match halves", match_value, 32'h5678_1234);

    // R8 halfword read latch
    bus_r(8'h2C, 2'd1, v); chk("R8 lower read", v, 32'h0000_BEEF);
    bus_w(8'h2C, 2'd2, 32'h1111_2222);
    bus_r(8'h2E, 2'd1, v); chk("R8 latched upper", v, 32'h0000_DEAD);
    bus_r(8'h00, 2'd1, v); chk("R8 id lower", v, 32'h21);
    bus_r(8'h02, 2'd1, v); chk("R8 id upper", v, 32'h0);

    // R11 strobes and counter readback
    bus_w(8'h30, 2'd2, 32'h0);
    chk("R11 reload strobe", {31'h0, s_reload}, 32'h1);
    bus_w(8'h28, 2'd2, 32'h0000_0055);
    chk("R11 cnt_wr strobe", {31'h0, s_cntwr}, 32'h1);
    chk("R11 cnt data", s_cntdata, 32'h55);
    bus_r(8'h28, 2'd2, v); chk("R11 cnt read", v, cnt_val);

    // R13 byte accesses
    bus_w(8'h2C, 2'd0, 32'hFFFF_FFFF);
    chk("R13 byte write ignored", load_value, 32'h1111_2222);
    bus_r(8'h00, 2'd0, v); chk("R13 byte read zero", v, 32'h0);

    // R14 capture re-arm
    bus_w(8'h24, 2'd2, 32'h0000_0100); chk("R14 none->rising", {31'h0, s_rearm}, 32'h1);
    bus_w(8'h24, 2'd2, 32'h0000_0200); chk("R14 rising->falling", {31'h0, s_rearm}, 32'h0);
    bus_w(8'h18, 2'd2, 32'h0000_0004); chk("R14 status bit2", {31'h0, s_rearm}, 32'h1);
    bus_w(8'h18, 2'd2, 32'h0000_0003); chk("R14 status no bit2", {31'h0, s_rearm}, 32'h0);
    bus_w(8'h24, 2'd2, 32'h0);

    // R3 enable width
    bus_w(8'h1C, 2'd2, 32'hFFFF_FFFF); bus_r(8'h1C, 2'd2, v); chk("R3 ie width", v, 32'h7);
    bus_w(8'h20, 2'd2, 32'hFFFF_FFF8); bus_r(8'h20, 2'd2, v); chk("R3 we width", v, 32'h0);

    // R4 directed: match event and clear of bit 0 in the same cycle
    @(negedge clk);
    evt_match = 1'b1; bus_addr = 8'h18; bus_size = 2'd2; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    evt_match = 1'b0; bus_wr = 1'b0;
    #1 chk("R4 set wins irq", {31'h0, irq}, 32'h1);
    bus_r(8'h18, 2'd2, v); chk("R4 set wins status", v, 32'h1);
    bus_w(8'h18, 2'd2, 32'h1);
    #1 chk("R4 cleared irq", {31'h0, irq}, 32'h0);

    // R3 R4 R5 random mix
    st_m = 3'b000; ie_m = 3'b111; we_m = 3'b000;
    for (int i = 0; i < 160; i++) begin
      if (i % 10 == 0) begin
        ie_m = 3'($urandom); we_m = 3'($urandom);
        bus_w(8'h1C, 2'd2, {29'h0, ie_m});
        bus_w(8'h20, 2'd2, {29'h0, we_m});
      end
      ev  = 3'($urandom);
      clr = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
      @(negedge clk);
      {evt_capt, evt_ovf, evt_match} = ev;
      if (clr != 3'b000) begin
        bus_addr = 8'h18; bus_size = 2'd2; bus_wdata = {29'h0, clr}; bus_wr = 1'b1;
      end
      @(negedge clk);
      {evt_capt, evt_ovf, evt_match} = 3'b000; bus_wr = 1'b0;
      st_m = model_status(st_m, clr, ev, ie_m);
      #1;
      chk("R5 wake pulse", {31'h0, wake}, {31'h0, |(ev & we_m)});
      chk("R4 irq level", {31'h0, irq}, {31'h0, st_m != 3'b000});
      bus_r(8'h18, 2'd2, v); chk("R3 status", v, {29'h0, st_m});
      #1 chk("R5 wake one cycle", {31'h0, wake}, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule